// File: doc/BRIEF.md
# Line-Watch Idle Wake Controller

This block decides when a sleeping logical core wakes from a user-level idle wait. Software first arms a watch on one 64-byte cache line. A later monitored wait puts the core into a low-power idle sub-state. Three events can wake the core: a snooped store into the watched line, a 64-bit timestamp deadline, or an interrupt request. A second command, the timed pause, sleeps the same way but takes no notice of the watch.

A privileged limit, counted in timestamp ticks, bounds every sleep. When that limit is what ends the sleep, the controller raises a carry flag so that software can tell the sleep was cut short. On wake-up the controller emits a one-cycle completion pulse and a reason code. The reason code and the carry flag hold their values until the next completion.

The controller watches one line at a time. It does not model coherence or power gating.

Top module: `idle_wait_unit`

## Requirements
- R1: The arm command (`cmd_op` = 1) records address bits [47:6] only. A snooped store to any byte of that 64-byte line counts as a hit. A store to any other line is not a hit.
- R2: A monitored wait (`cmd_op` = 2) raises `idle` after the clock edge that accepts it. The wait ends at the first edge where one of these holds: an interrupt, a watched-line hit, or `tsc` >= deadline. After that edge `idle` is 0 and `done` is 1 for exactly one cycle.
- R3: The deadline is the 64-bit value {`cmd_dl_hi`, `cmd_dl_lo`}, and it is compared unsigned against `tsc`. This comparison stays correct when the deadline crosses a boundary in the low half.
- R4: `cmd_hint` chooses the idle sub-state: 0 is the deep state and 1 is the shallow state. `substate` shows this choice and stays stable while `idle` is 1.
- R5: With `sleep_cap` nonzero, the sleep ends at the first edge where `tsc` minus the start value reaches `sleep_cap`, if no other event has ended it first. The reason is then 4 (limit) and `carry` is 1. A `sleep_cap` of 0 disables the limit.
- R6: A timed pause (`cmd_op` = 3) ends only on an interrupt, the deadline or the limit. Hits on the watched line do not end it.
- R7: If a monitored wait is issued while no line is armed, or after the armed line has already been hit (including a hit in the issue cycle), it completes after that edge with `done` = 1 and reason 5. It does not enter idle.
- R8: If the deadline is at or below `tsc` when a wait or pause is issued, the command completes after that edge with reason 3 and `carry` = 0. It does not enter idle.
- R9: When several events fall on the same edge, the reported reason follows this order: interrupt (1), then hit (2), then deadline (3), then limit (4). `carry` is 1 only when the reason is 4.
- R10: Every completed monitored wait disarms the watch. A new arm command replaces the previously armed line and clears any recorded hit.
- R11: Commands presented while `idle` is 1 are ignored.
- R12: After reset, `idle`, `done`, `carry` and `substate` are 0, `reason` is 0, and no line is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 none, 1 arm, 2 monitored wait, 3 timed pause |
| cmd_addr | input | 48 | Byte address for the arm command |
| cmd_dl_hi | input | 32 | Upper half of the deadline |
| cmd_dl_lo | input | 32 | Lower half of the deadline |
| cmd_hint | input | 1 | Sub-state hint: 0 deep, 1 shallow |
| sleep_cap | input | 32 | Privileged sleep limit in ticks; 0 disables it |
| tsc | input | 64 | Free-running timestamp counter |
| irq | input | 1 | Interrupt request |
| snoop_valid | input | 1 | Snooped store present this cycle |
| snoop_addr | input | 48 | Byte address of the snooped store |
| idle | output | 1 | Core is asleep |
| substate | output | 1 | Selected idle sub-state |
| done | output | 1 | One-cycle completion pulse |
| reason | output | 3 | Wake reason of the last completion |
| carry | output | 1 | Last sleep was cut short by the limit |

## Verification
Wake events can coincide, and the priority order must then decide the reason. The bench provokes collisions on purpose: an interrupt on the same edge as a line hit, a hit on the same edge as the deadline, and a limit that expires on the same tick as the deadline. It also produces such collisions by chance, by drawing event steps, deadline offsets and limits from overlapping small ranges. Each case is judged by a bench model that walks the sleep one tick at a time and applies the priority order. The model's result must match the pulse cycle, the reason code and the carry flag.

// File: rtl/idle_wait_pkg.sv
package idle_wait_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ARM   = 2'd1,
        OP_WAIT  = 2'd2,
        OP_PAUSE = 2'd3
    } wait_op_e;

    typedef enum logic [2:0] {
        WR_NONE     = 3'd0,
        WR_IRQ      = 3'd1,
        WR_HIT      = 3'd2,
        WR_DEADLINE = 3'd3,
        WR_LIMIT    = 3'd4,
        WR_NOMON    = 3'd5
    } wake_rsn_e;

    typedef enum logic {
        SUB_DEEP    = 1'b0,
        SUB_SHALLOW = 1'b1
    } idle_sub_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_IDLE = 1'b1
    } wait_state_e;

    typedef struct packed {
        logic irq;
        logic hit;
        logic deadline;
        logic limit;
    } wake_evt_t;

    function automatic wake_rsn_e pick_reason(input wake_evt_t e);
        if (e.irq)           return WR_IRQ;
        else if (e.hit)      return WR_HIT;
        else if (e.deadline) return WR_DEADLINE;
        else if (e.limit)    return WR_LIMIT;
        else                 return WR_NONE;
    endfunction

    function automatic logic any_event(input wake_evt_t e);
        return e.irq | e.hit | e.deadline | e.limit;
    endfunction

endpackage

// File: rtl/idle_line_monitor.sv
module idle_line_monitor #(
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_req,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic              disarm,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              armed,
    output logic              hit_now,
    output logic              hit_seen
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int TAG_W = ADDR_W - OFF_W;

    logic [TAG_W-1:0] tag_q;
    logic             armed_q;
    logic             hit_q;
    logic             unused_offsets;

    // byte offsets inside the line never take part in the match
    assign unused_offsets = ^{arm_addr[OFF_W-1:0], snoop_addr[OFF_W-1:0]};

    assign hit_now  = armed_q && snoop_valid && (snoop_addr[ADDR_W-1:OFF_W] == tag_q);
    assign hit_seen = hit_q | hit_now;
    assign armed    = armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            hit_q   <= 1'b0;
            tag_q   <= '0;
        end else if (arm_req) begin
            armed_q <= 1'b1;
            hit_q   <= 1'b0;
            tag_q   <= arm_addr[ADDR_W-1:OFF_W];
        end else if (disarm) begin
            armed_q <= 1'b0;
            hit_q   <= 1'b0;
        end else if (hit_now) begin
            hit_q   <= 1'b1;
        end
    end
endmodule

// File: rtl/idle_wake_eval.sv
module idle_wake_eval
    import idle_wait_pkg::*;
#(
    parameter int TSC_W = 64,
    parameter int CAP_W = 32
) (
    input  logic [TSC_W-1:0] tsc,
    input  logic [TSC_W-1:0] deadline,
    input  logic [TSC_W-1:0] start_tsc,
    input  logic [CAP_W-1:0] cap,
    input  logic             irq,
    input  logic             hit_now,
    input  logic             use_mon,
    output wake_rsn_e        why,
    output logic             fire
);
    localparam int PAD_W = TSC_W - CAP_W;

    logic [TSC_W-1:0] elapsed;
    logic [TSC_W-1:0] cap_wide;
    wake_evt_t        evt;

    assign elapsed  = tsc - start_tsc;
    assign cap_wide = {{PAD_W{1'b0}}, cap};

    always_comb begin
        evt.irq      = irq;
        evt.hit      = use_mon & hit_now;
        evt.deadline = (tsc >= deadline);
        evt.limit    = (cap != '0) && (elapsed >= cap_wide);
    end

    assign why  = pick_reason(evt);
    assign fire = any_event(evt);
endmodule

// File: rtl/idle_wait_ctrl.sv
module idle_wait_ctrl
    import idle_wait_pkg::*;
#(
    parameter int TSC_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  wait_op_e         op,
    input  logic [TSC_W-1:0] deadline_in,
    input  logic             hint,
    input  logic [TSC_W-1:0] tsc,
    input  logic             armed,
    input  logic             hit_seen,
    input  logic             fire,
    input  wake_rsn_e        why,
    output logic             arm_req,
    output logic             disarm,
    output logic [TSC_W-1:0] deadline_q,
    output logic [TSC_W-1:0] start_q,
    output logic             use_mon_q,
    output logic             idle,
    output idle_sub_e        substate,
    output logic             done,
    output wake_rsn_e        reason,
    output logic             carry
);
    wait_state_e state_q;
    logic cmd_live, is_wait, is_pause, start_past;
    logic imm_nomon, imm_past, go_idle, wake_now;

    assign cmd_live   = cmd_valid && (state_q == ST_RUN);
    assign arm_req    = cmd_live && (op == OP_ARM);
    assign is_wait    = cmd_live && (op == OP_WAIT);
    assign is_pause   = cmd_live && (op == OP_PAUSE);
    assign start_past = (deadline_in <= tsc);

    assign imm_nomon = is_wait && (!armed || hit_seen);
    assign imm_past  = (is_wait || is_pause) && !imm_nomon && start_past;
    assign go_idle   = (is_wait || is_pause) && !imm_nomon && !start_past;
    assign wake_now  = (state_q == ST_IDLE) && fire;
    assign disarm    = (is_wait && !go_idle) || (wake_now && use_mon_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_RUN;
            deadline_q <= '0;
            start_q    <= '0;
            use_mon_q  <= 1'b0;
            substate   <= SUB_DEEP;
            done       <= 1'b0;
            reason     <= WR_NONE;
            carry      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (imm_nomon) begin
                done   <= 1'b1;
                reason <= WR_NOMON;
                carry  <= 1'b0;
            end else if (imm_past) begin
                done   <= 1'b1;
                reason <= WR_DEADLINE;
                carry  <= 1'b0;
            end else if (go_idle) begin
                state_q    <= ST_IDLE;
                deadline_q <= deadline_in;
                start_q    <= tsc;
                use_mon_q  <= is_wait;
                substate   <= idle_sub_e'(hint);
            end else if (wake_now) begin
                state_q <= ST_RUN;
                done    <= 1'b1;
                reason  <= why;
                carry   <= (why == WR_LIMIT);
            end
        end
    end

    assign idle = (state_q == ST_IDLE);
endmodule

// File: rtl/idle_wait_unit.sv
module idle_wait_unit
    import idle_wait_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 64,
    parameter int TSC_W      = 64,
    parameter int CAP_W      = 32,
    localparam int HALF_W    = TSC_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [HALF_W-1:0] cmd_dl_hi,
    input  logic [HALF_W-1:0] cmd_dl_lo,
    input  logic              cmd_hint,
    input  logic [CAP_W-1:0]  sleep_cap,
    input  logic [TSC_W-1:0]  tsc,
    input  logic              irq,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              idle,
    output logic              substate,
    output logic              done,
    output logic [2:0]        reason,
    output logic              carry
);
    logic             arm_req, disarm, armed, hit_now, hit_seen;
    logic             use_mon_q, fire;
    logic [TSC_W-1:0] deadline_in, deadline_q, start_q;
    wake_rsn_e        why, reason_e;
    idle_sub_e        sub_e;

    assign deadline_in = {cmd_dl_hi, cmd_dl_lo};

    idle_line_monitor #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_mon (
        .clk(clk), .rst(rst),
        .arm_req(arm_req), .arm_addr(cmd_addr), .disarm(disarm),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .armed(armed), .hit_now(hit_now), .hit_seen(hit_seen)
    );

    idle_wake_eval #(.TSC_W(TSC_W), .CAP_W(CAP_W)) u_eval (
        .tsc(tsc), .deadline(deadline_q), .start_tsc(start_q), .cap(sleep_cap),
        .irq(irq), .hit_now(hit_now), .use_mon(use_mon_q),
        .why(why), .fire(fire)
    );

    idle_wait_ctrl #(.TSC_W(TSC_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .op(wait_op_e'(cmd_op)),
        .deadline_in(deadline_in), .hint(cmd_hint), .tsc(tsc),
        .armed(armed), .hit_seen(hit_seen), .fire(fire), .why(why),
        .arm_req(arm_req), .disarm(disarm),
        .deadline_q(deadline_q), .start_q(start_q), .use_mon_q(use_mon_q),
        .idle(idle), .substate(sub_e), .done(done), .reason(reason_e), .carry(carry)
    );

    assign substate = sub_e;
    assign reason   = reason_e;
endmodule

// File: rtl/idle_wait_unit_chk.sv
module idle_wait_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq,
    input logic       idle,
    input logic       substate,
    input logic       done,
    input logic [2:0] reason,
    input logic       carry
);
    // R2: no completion pulse while still asleep
    p_no_pulse_asleep_r2: assert property (@(posedge clk) disable iff (rst)
        !(idle && done));

    // R2: leaving idle is always marked by a completion pulse
    p_exit_pulses_r2: assert property (@(posedge clk) disable iff (rst)
        idle |=> (idle || done));

    // R9: an interrupt during sleep wins on the next edge
    p_irq_first_r9: assert property (@(posedge clk) disable iff (rst)
        (idle && irq) |=> (done && reason == 3'd1));

    // R5: carry only accompanies a limit wake
    p_carry_limit_r5: assert property (@(posedge clk) disable iff (rst)
        (done && carry) |-> (reason == 3'd4));

    // R4: sub-state stays put across a sleep
    p_sub_steady_r4: assert property (@(posedge clk) disable iff (rst)
        idle |=> (!idle || $stable(substate)));

    // R7: an unarmed completion never follows a sleep cycle
    p_nomon_direct_r7: assert property (@(posedge clk) disable iff (rst)
        (done && reason == 3'd5) |-> !$past(idle));
endmodule

bind idle_wait_unit idle_wait_unit_chk u_chk (
    .clk(clk), .rst(rst), .irq(irq), .idle(idle), .substate(substate),
    .done(done), .reason(reason), .carry(carry)
);

// File: tb/idle_wait_unit_bench.sv
module idle_wait_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [47:0] cmd_addr = '0;
    logic [31:0] cmd_dl_hi = '0, cmd_dl_lo = '0;
    logic        cmd_hint = 1'b0;
    logic [31:0] sleep_cap = '0;
    logic [63:0] tsc = 64'h0000_0000_FFFF_FFC0;
    logic        irq = 1'b0;
    logic        snoop_valid = 1'b0;
    logic [47:0] snoop_addr = '0;
    logic        idle, substate, done, carry;
    logic [2:0]  reason;

    int checks = 0;
    int errors = 0;
    logic [41:0] cur_line = 42'h1234;
    logic [41:0] noise_line = 42'h1235;

    always #2.5 clk = ~clk;

    idle_wait_unit u_idle_wait_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_dl_hi(cmd_dl_hi), .cmd_dl_lo(cmd_dl_lo),
        .cmd_hint(cmd_hint), .sleep_cap(sleep_cap), .tsc(tsc), .irq(irq),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .idle(idle), .substate(substate), .done(done), .reason(reason), .carry(carry)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        tsc = tsc + 64'd1;
    endtask

    task automatic arm(input logic [41:0] line, input logic [5:0] off);
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_addr = {line, off};
        tick();
        cmd_valid = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic snoop_once(input logic [41:0] line, input logic [5:0] off);
        snoop_valid = 1'b1; snoop_addr = {line, off};
        tick();
        snoop_valid = 1'b0;
    endtask

    // expected result of a sleep, walked tick by tick with the priority order
    function automatic void model(input int op, input int dl_off, input int cap,
                                  input int irq_k, input int hit_k,
                                  output int wk, output int rsn);
        wk = 0; rsn = 0;
        for (int k = 1; k <= 400; k++) begin
            if (k == irq_k) begin wk = k; rsn = 1; return; end
            if (op == 2 && k == hit_k) begin wk = k; rsn = 2; return; end
            if (k >= dl_off) begin wk = k; rsn = 3; return; end
            if (cap != 0 && k >= cap) begin wk = k; rsn = 4; return; end
        end
    endfunction

    task automatic run_wait(input int op, input int dl_off, input int cap,
                            input int irq_k, input int hit_k, input int arm_k,
                            input logic [41:0] arm_line, input logic hint,
                            input string req);
        logic [63:0] dl;
        int wk, rsn;
        dl = tsc + 64'(dl_off);
        sleep_cap = 32'(cap);
        cmd_valid = 1'b1; cmd_op = 2'(op);
        cmd_dl_hi = dl[63:32]; cmd_dl_lo = dl[31:0]; cmd_hint = hint;
        tick();
        cmd_valid = 1'b0; cmd_op = 2'd0;
        if (dl_off == 0) begin
            check({req, " R8 done"}, 64'(done), 64'd1);
            check({req, " R8 reason"}, 64'(reason), 64'd3);
            check({req, " R8 carry"}, 64'(carry), 64'd0);
            check({req, " R8 idle"}, 64'(idle), 64'd0);
            tick();
            return;
        end
        check({req, " R2 idle"}, 64'(idle), 64'd1);
        check({req, " R4 substate"}, 64'(substate), 64'(hint));
        model(op, dl_off, cap, irq_k, hit_k, wk, rsn);
        for (int s = 1; s <= wk; s++) begin
            irq = (s == irq_k);
            snoop_valid = 1'b1;
            snoop_addr = (s == hit_k) ? {cur_line, 6'(s * 13)} : {noise_line, 6'(s * 7)};
            if (s == arm_k) begin
                cmd_valid = 1'b1; cmd_op = 2'd1; cmd_addr = {arm_line, 6'd0};
            end
            tick();
            cmd_valid = 1'b0; cmd_op = 2'd0;
            if (s < wk) begin
                if (idle !== 1'b1 || done !== 1'b0)
                    check({req, " R2 early wake"}, {idle, done}, 64'h2);
            end
        end
        irq = 1'b0; snoop_valid = 1'b0;
        check({req, " R2 done"}, 64'(done), 64'd1);
        check({req, " R2 idle cleared"}, 64'(idle), 64'd0);
        check({req, " R9 reason"}, 64'(reason), 64'(rsn));
        check({req, " R5 carry"}, 64'(carry), 64'(rsn == 4));
        tick();
        check({req, " R2 pulse"}, 64'(done), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20240605));
        repeat (3) tick();
        rst = 1'b0;
        #0;
        check("R12 idle", 64'(idle), 64'd0);
        check("R12 done", 64'(done), 64'd0);
        check("R12 reason", 64'(reason), 64'd0);
        check("R12 carry", 64'(carry), 64'd0);
        check("R12 substate", 64'(substate), 64'd0);

        // R12/R7: nothing armed after reset
        cmd_valid = 1'b1; cmd_op = 2'd2;
        {cmd_dl_hi, cmd_dl_lo} = tsc + 64'd50;
        tick();
        cmd_valid = 1'b0; cmd_op = 2'd0;
        check("R7 unarmed done", 64'(done), 64'd1);
        check("R7 unarmed reason", 64'(reason), 64'd5);
        check("R7 unarmed idle", 64'(idle), 64'd0);
        tick();

        // R7/R1: hit at a far offset between arm and wait
        arm(cur_line, 6'd0);
        snoop_once(cur_line, 6'd37);
        cmd_valid = 1'b1; cmd_op = 2'd2;
        {cmd_dl_hi, cmd_dl_lo} = tsc + 64'd50;
        tick();
        cmd_valid = 1'b0; cmd_op = 2'd0;
        check("R7 prior hit reason", 64'(reason), 64'd5);
        check("R7 prior hit done", 64'(done), 64'd1);
        tick();

        // R1/R2/R4/R3: hit after noise on a neighbouring line, deadline crosses low half
        arm(cur_line, 6'd5);
        run_wait(2, 80, 0, 0, 9, 0, '0, 1'b1, "R1 line hit");
        // R10: disarmed after completion
        cmd_valid = 1'b1; cmd_op = 2'd2;
        {cmd_dl_hi, cmd_dl_lo} = tsc + 64'd50;
        tick();
        cmd_valid = 1'b0; cmd_op = 2'd0;
        check("R10 disarm reason", 64'(reason), 64'd5);
        tick();

        arm(cur_line, 6'd0);
        run_wait(2, 0, 0, 0, 0, 0, '0, 1'b0, "R8 past");
        arm(cur_line, 6'd0);
        run_wait(2, 20, 5, 0, 0, 0, '0, 1'b0, "R5 limit alone");
        arm(cur_line, 6'd0);
        run_wait(2, 12, 12, 0, 0, 0, '0, 1'b0, "R9 limit tie");
        arm(cur_line, 6'd0);
        run_wait(2, 30, 0, 0, 0, 0, '0, 1'b0, "R5 cap off R3");
        arm(cur_line, 6'd0);
        run_wait(2, 30, 0, 4, 4, 0, '0, 1'b0, "R9 irq+hit");
        arm(cur_line, 6'd0);
        run_wait(2, 6, 0, 0, 6, 0, '0, 1'b0, "R9 hit+deadline");
        arm(cur_line, 6'd0);
        run_wait(3, 6, 0, 0, 2, 0, '0, 1'b1, "R6 pause");

        // R10: re-arm replaces the old line
        noise_line = cur_line;
        cur_line = 42'h2_0000_0777;
        arm(noise_line, 6'd0);
        arm(cur_line, 6'd9);
        run_wait(2, 40, 0, 0, 3, 0, '0, 1'b0, "R10 rearm");

        // R11: arm during a pause is ignored, old line stays watched
        arm(cur_line, 6'd0);
        run_wait(3, 10, 0, 0, 0, 2, noise_line, 1'b0, "R11 ignored cmd");
        run_wait(2, 40, 0, 0, 5, 0, '0, 1'b0, "R11 old line kept");

        // constrained random mix
        for (int it = 0; it < 60; it++) begin
            int op, dl_off, cap, irq_k, hit_k;
            cur_line = 42'($urandom);
            noise_line = cur_line ^ 42'h1;
            op = ($urandom_range(0, 1) == 0) ? 2 : 3;
            dl_off = $urandom_range(1, 40);
            cap = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 40);
            irq_k = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, 45);
            hit_k = $urandom_range(1, 45);
            arm(cur_line, 6'($urandom));
            run_wait(op, dl_off, cap, irq_k, hit_k, 0, '0, 1'($urandom), "R2 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule